// File: doc/BRIEF.md
# Reservation Station Wakeup and Select

This block is the scheduling window that sits between rename and a single functional unit in an out-of-order core. Rename hands it one instruction per cycle. The instruction carries the tag that will name its result and two source operands. Each operand arrives either as a value that is already known, or as the tag of the instruction that will produce it. The window keeps the instruction until both operands hold values, then sends it to the functional unit.

A shared result bus carries a producer tag and its value. Every waiting operand compares its tag against the bus. On a match, the operand takes the value and counts as ready. The select stage looks at the entries whose operands are all ready. Each cycle it issues the one in the lowest slot, and that slot becomes free at the same clock edge. Issue order therefore follows readiness, not arrival order. When every slot is occupied, the block asserts backpressure toward rename.

Top module: `rs_window`

## Requirements
- R1: After a synchronous active-low reset, all slots are empty, `issue_valid` is 0 and `alloc_full` is 0.
- R2: An instruction is accepted at a rising edge when `alloc_valid` is 1 and `alloc_full` is 0. It is written into the free slot with the lowest index, and that index is later reported on `issue_slot`.
- R3: A waiting operand whose tag equals `bcast_tag` while `bcast_valid` is 1 takes `bcast_val` and is ready from the next cycle. While `bcast_valid` is 0, a matching tag has no effect.
- R4: An operand that arrives as a tag in the same cycle as a matching broadcast is stored already ready, holding the broadcast value.
- R5: One broadcast wakes every waiting operand that carries its tag, across all slots and on both operands of one slot.
- R6: `issue_valid` is 1 in any cycle in which an occupied slot has both operands ready. `issue_slot` is the lowest such index, and `issue_dest`, `issue_a` and `issue_b` are that slot's contents. That slot is empty after the edge.
- R7: No slot is issued while either of its operands is waiting. The values issued are exactly those supplied at allocation or captured from the bus. Every accepted instruction issues once its producers have broadcast.
- R8: `alloc_full` is 1 exactly when all 8 slots are occupied. An allocation presented while full changes nothing.
- R9: An operand that is already ready ignores later broadcasts, even when its stored tag field equals the broadcast tag. It stays ready until its slot issues.
- R10: A slot freed by issue can be allocated only from the following cycle. An issue in the same cycle does not lower `alloc_full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_valid | input | 1 | Rename presents an instruction |
| alloc_dest | input | 4 | Tag naming the instruction's result |
| alloc_a_rdy | input | 1 | Operand A holds a value (1) or waits on a tag (0) |
| alloc_a_tag | input | 4 | Producer tag for operand A |
| alloc_a_val | input | 32 | Value for operand A |
| alloc_b_rdy | input | 1 | Operand B holds a value (1) or waits on a tag (0) |
| alloc_b_tag | input | 4 | Producer tag for operand B |
| alloc_b_val | input | 32 | Value for operand B |
| alloc_full | output | 1 | All slots occupied; allocation is refused |
| bcast_valid | input | 1 | Result bus carries a result this cycle |
| bcast_tag | input | 4 | Tag of the broadcast result |
| bcast_val | input | 32 | Value of the broadcast result |
| issue_valid | output | 1 | An instruction is sent to the functional unit |
| issue_slot | output | 3 | Slot index of the issued instruction |
| issue_dest | output | 4 | Result tag of the issued instruction |
| issue_a | output | 32 | Operand A value of the issued instruction |
| issue_b | output | 32 | Operand B value of the issued instruction |

## Verification
The hardest cases to reach from the ports need two things to happen in one cycle.

- **Result arriving with allocation.** A result can arrive in the very cycle its consumer is being allocated. The stimulus drives both ports in one cycle with matching tags, so the capture path at allocation is used.
- **Full window releasing a slot.** The window can be full in the same cycle that it issues. To reach this, eight entries are loaded that all wait on tags. Refused allocations are then attempted, and the entries are released one tag at a time.

A long random phase follows, and then a drain that broadcasts every tag. The drain shows that readiness-ordered issue loses no instruction, compared each cycle against a behavioural model.

// File: rtl/rs_pkg.sv
// Package: shared widths and the operand record for the scheduling window.
// Assumes tags and data widths are fixed per core configuration.
package rs_pkg;
    localparam int TAG_W  = 4;
    localparam int DATA_W = 32;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [DATA_W-1:0] data_t;

    // One source operand: either a held value or a producer tag to wait on.
    typedef struct packed {
        logic  rdy;
        tag_t  tag;
        data_t val;
    } opnd_t;
endpackage

// File: rtl/rs_operand_wake.sv
// Module: next-state of one source operand against the result bus.
// Assumes a ready operand must never be disturbed by a broadcast.
module rs_operand_wake
    import rs_pkg::*;
(
    input  opnd_t cur,
    input  logic  bc_valid,
    input  tag_t  bc_tag,
    input  data_t bc_val,
    output opnd_t nxt
);
    // Capture the broadcast value when a waiting operand's tag matches.
    always_comb begin
        nxt = cur;
        if (!cur.rdy && bc_valid && (cur.tag == bc_tag)) begin
            nxt.rdy = 1'b1;
            nxt.val = bc_val;
        end
    end
endmodule

// File: rtl/rs_prio_pick.sv
// Module: fixed-priority picker, lowest set request bit wins.
// Assumes idx is meaningless when found is 0.
module rs_prio_pick #(
    parameter int W     = 8,
    localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top down so the lowest index is written last.
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/rs_window.sv
// Module: reservation station with tag-broadcast wakeup and one-wide select.
// Assumes: rename supplies at most one instruction per cycle, one result
// broadcast per cycle, and the functional unit accepts every issue.
// Issue is decided from registered state; a wakeup is visible next cycle.
module rs_window
    import rs_pkg::*;
#(
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [TAG_W-1:0]  alloc_dest,
    input  logic              alloc_a_rdy,
    input  logic [TAG_W-1:0]  alloc_a_tag,
    input  logic [DATA_W-1:0] alloc_a_val,
    input  logic              alloc_b_rdy,
    input  logic [TAG_W-1:0]  alloc_b_tag,
    input  logic [DATA_W-1:0] alloc_b_val,
    output logic              alloc_full,
    input  logic              bcast_valid,
    input  logic [TAG_W-1:0]  bcast_tag,
    input  logic [DATA_W-1:0] bcast_val,
    output logic              issue_valid,
    output logic [IDX_W-1:0]  issue_slot,
    output logic [TAG_W-1:0]  issue_dest,
    output logic [DATA_W-1:0] issue_a,
    output logic [DATA_W-1:0] issue_b
);
    logic [DEPTH-1:0] valid_q;
    opnd_t            opa_q [DEPTH];
    opnd_t            opb_q [DEPTH];
    tag_t             dst_q [DEPTH];

    opnd_t            opa_w [DEPTH];
    opnd_t            opb_w [DEPTH];
    logic [DEPTH-1:0] rdy_a;
    logic [DEPTH-1:0] rdy_b;
    logic [DEPTH-1:0] ready_vec;

    opnd_t            in_a, in_b, in_a_w, in_b_w;
    logic             free_found, sel_found, alloc_fire;
    logic [IDX_W-1:0] free_idx, sel_idx;

    // Per-slot wakeup comparators and readiness bits.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        rs_operand_wake u_wake_a (
            .cur(opa_q[g]), .bc_valid(bcast_valid), .bc_tag(bcast_tag),
            .bc_val(bcast_val), .nxt(opa_w[g])
        );
        rs_operand_wake u_wake_b (
            .cur(opb_q[g]), .bc_valid(bcast_valid), .bc_tag(bcast_tag),
            .bc_val(bcast_val), .nxt(opb_w[g])
        );
        assign rdy_a[g] = opa_q[g].rdy;
        assign rdy_b[g] = opb_q[g].rdy;
    end

    assign ready_vec = valid_q & rdy_a & rdy_b;

    // Incoming operands are compared against this cycle's broadcast too.
    assign in_a = '{rdy: alloc_a_rdy, tag: alloc_a_tag, val: alloc_a_val};
    assign in_b = '{rdy: alloc_b_rdy, tag: alloc_b_tag, val: alloc_b_val};

    rs_operand_wake u_wake_in_a (
        .cur(in_a), .bc_valid(bcast_valid), .bc_tag(bcast_tag),
        .bc_val(bcast_val), .nxt(in_a_w)
    );
    rs_operand_wake u_wake_in_b (
        .cur(in_b), .bc_valid(bcast_valid), .bc_tag(bcast_tag),
        .bc_val(bcast_val), .nxt(in_b_w)
    );

    // Lowest free slot for allocation.
    rs_prio_pick #(.W(DEPTH)) u_free_pick (
        .req(~valid_q), .found(free_found), .idx(free_idx)
    );

    // Lowest fully ready slot for issue.
    rs_prio_pick #(.W(DEPTH)) u_sel_pick (
        .req(ready_vec), .found(sel_found), .idx(sel_idx)
    );

    assign alloc_full = ~free_found;
    assign alloc_fire = alloc_valid & free_found;

    // Drive the functional unit from the selected slot.
    assign issue_valid = sel_found;
    assign issue_slot  = sel_idx;
    assign issue_dest  = dst_q[sel_idx];
    assign issue_a     = opa_q[sel_idx].val;
    assign issue_b     = opb_q[sel_idx].val;

    // Slot state: wakeup every cycle, free on issue, fill on allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                opa_q[i] <= '0;
                opb_q[i] <= '0;
                dst_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                opa_q[i] <= opa_w[i];
                opb_q[i] <= opb_w[i];
            end
            if (sel_found) valid_q[sel_idx] <= 1'b0;
            if (alloc_fire) begin
                valid_q[free_idx] <= 1'b1;
                opa_q[free_idx]   <= in_a_w;
                opb_q[free_idx]   <= in_b_w;
                dst_q[free_idx]   <= alloc_dest;
            end
        end
    end
endmodule

// File: rtl/rs_window_chk.sv
// Module: temporal checks on the scheduling window, attached by bind.
// Assumes it observes slot occupancy and readiness bits of the top.
module rs_window_chk #(
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DEPTH-1:0] valid_q,
    input logic [DEPTH-1:0] rdy_a,
    input logic [DEPTH-1:0] rdy_b,
    input logic             issue_valid,
    input logic [IDX_W-1:0] issue_slot,
    input logic             alloc_full
);
    logic [DEPTH-1:0] ok_vec;
    logic [DEPTH-1:0] below;

    assign ok_vec = valid_q & rdy_a & rdy_b;
    assign below  = (DEPTH'(1) << issue_slot) - DEPTH'(1);

    assert_issue_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> ok_vec[issue_slot]);

    assert_issue_lowest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> ((ok_vec & below) == '0));

    assert_ready_not_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_vec != '0) |-> issue_valid);

    assert_issue_frees_R10: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> !valid_q[$past(issue_slot)]);

    assert_full_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_full && !issue_valid) |=> alloc_full);

    for (genvar g = 0; g < DEPTH; g++) begin : g_keep
        assert_ready_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_q[g] && rdy_a[g] && !(issue_valid && issue_slot == IDX_W'(g)))
            |=> (valid_q[g] && rdy_a[g]));
    end
endmodule

bind rs_window rs_window_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .valid_q(valid_q), .rdy_a(rdy_a),
    .rdy_b(rdy_b), .issue_valid(issue_valid), .issue_slot(issue_slot),
    .alloc_full(alloc_full)
);

// File: tb/tb_rs_window.sv
module tb_rs_window;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        alloc_valid, alloc_a_rdy, alloc_b_rdy;
    logic [3:0]  alloc_dest, alloc_a_tag, alloc_b_tag;
    logic [31:0] alloc_a_val, alloc_b_val;
    logic        alloc_full;
    logic        bcast_valid;
    logic [3:0]  bcast_tag;
    logic [31:0] bcast_val;
    logic        issue_valid;
    logic [2:0]  issue_slot;
    logic [3:0]  issue_dest;
    logic [31:0] issue_a, issue_b;

    int n_tests = 0, n_fail = 0, n_alloc = 0, n_issue = 0;

    // Reference model state
    bit          m_v [N];
    bit          m_ar[N], m_br[N];
    logic [3:0]  m_at[N], m_bt[N], m_d[N];
    logic [31:0] m_av[N], m_bv[N];

    always #10 clk = ~clk;

    rs_window dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_dest(alloc_dest),
        .alloc_a_rdy(alloc_a_rdy), .alloc_a_tag(alloc_a_tag), .alloc_a_val(alloc_a_val),
        .alloc_b_rdy(alloc_b_rdy), .alloc_b_tag(alloc_b_tag), .alloc_b_val(alloc_b_val),
        .alloc_full(alloc_full),
        .bcast_valid(bcast_valid), .bcast_tag(bcast_tag), .bcast_val(bcast_val),
        .issue_valid(issue_valid), .issue_slot(issue_slot), .issue_dest(issue_dest),
        .issue_a(issue_a), .issue_b(issue_b)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        alloc_valid = 0; alloc_dest = 0;
        alloc_a_rdy = 0; alloc_a_tag = 0; alloc_a_val = 0;
        alloc_b_rdy = 0; alloc_b_tag = 0; alloc_b_val = 0;
        bcast_valid = 0; bcast_tag = 0; bcast_val = 0;
    endtask

    task automatic put(input logic [3:0] d, input bit ar, input logic [3:0] at,
                       input logic [31:0] av, input bit br, input logic [3:0] bt,
                       input logic [31:0] bv);
        alloc_valid = 1; alloc_dest = d;
        alloc_a_rdy = ar; alloc_a_tag = at; alloc_a_val = av;
        alloc_b_rdy = br; alloc_b_tag = bt; alloc_b_val = bv;
    endtask

    task automatic bc(input logic [3:0] t, input logic [31:0] v);
        bcast_valid = 1; bcast_tag = t; bcast_val = v;
    endtask

    function automatic bit model_empty();
        for (int i = 0; i < N; i++) if (m_v[i]) return 0;
        return 1;
    endfunction

    // Compare outputs with the model, advance the model, cross one clock.
    task automatic step(input string req);
        int  sel = -1, fr = -1;
        bit  full = 1;
        #1;
        for (int i = 0; i < N; i++) begin
            if (!m_v[i]) full = 0;
            if (m_v[i] && m_ar[i] && m_br[i] && sel < 0) sel = i;
            if (!m_v[i] && fr < 0) fr = i;
        end
        chk(alloc_full === full, req, "alloc_full", 32'(alloc_full), 32'(full));
        chk(issue_valid === (sel >= 0), req, "issue_valid", 32'(issue_valid), 32'(sel >= 0));
        if (sel >= 0 && issue_valid === 1'b1) begin
            chk(issue_slot === 3'(sel), req, "issue_slot", 32'(issue_slot), 32'(sel));
            chk(issue_dest === m_d[sel], req, "issue_dest", 32'(issue_dest), 32'(m_d[sel]));
            chk(issue_a === m_av[sel], req, "issue_a", issue_a, m_av[sel]);
            chk(issue_b === m_bv[sel], req, "issue_b", issue_b, m_bv[sel]);
        end
        for (int i = 0; i < N; i++) begin
            if (m_v[i] && !m_ar[i] && bcast_valid && m_at[i] == bcast_tag) begin
                m_ar[i] = 1; m_av[i] = bcast_val;
            end
            if (m_v[i] && !m_br[i] && bcast_valid && m_bt[i] == bcast_tag) begin
                m_br[i] = 1; m_bv[i] = bcast_val;
            end
        end
        if (sel >= 0) begin m_v[sel] = 0; n_issue++; end
        if (alloc_valid && !full) begin
            m_v[fr] = 1; m_d[fr] = alloc_dest;
            m_ar[fr] = alloc_a_rdy; m_at[fr] = alloc_a_tag; m_av[fr] = alloc_a_val;
            m_br[fr] = alloc_b_rdy; m_bt[fr] = alloc_b_tag; m_bv[fr] = alloc_b_val;
            if (!m_ar[fr] && bcast_valid && m_at[fr] == bcast_tag) begin
                m_ar[fr] = 1; m_av[fr] = bcast_val;
            end
            if (!m_br[fr] && bcast_valid && m_bt[fr] == bcast_tag) begin
                m_br[fr] = 1; m_bv[fr] = bcast_val;
            end
            n_alloc++;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        for (int i = 0; i < N; i++) m_v[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        step("R1");

        // R2/R7: both ready, issues next cycle from slot 0
        put(4'h1, 1, 0, 32'h11, 1, 0, 32'h22); step("R2");
        idle(); step("R7");

        // R3: wait on tag 5; an invalid bus with tag 5 does nothing
        put(4'h2, 0, 4'h5, 0, 1, 0, 32'h33); step("R3");
        idle(); bcast_tag = 4'h5; bcast_val = 32'hDEAD; step("R3");
        bc(4'h5, 32'h55); step("R3");
        idle(); step("R3");
        step("R3");

        // R4: allocation meets its producer's broadcast in the same cycle
        put(4'h3, 0, 4'h6, 0, 0, 4'h6, 0); bc(4'h6, 32'h66); step("R4");
        idle(); step("R4");

        // R5/R6: two slots wait on tag 9, wake together, issue in slot order
        put(4'h4, 0, 4'h9, 0, 1, 0, 32'h1); step("R5");
        put(4'h5, 1, 0, 32'h2, 0, 4'h9, 0); step("R5");
        idle(); bc(4'h9, 32'h99); step("R5");
        idle(); step("R6");
        step("R6");
        step("R6");

        // R9: ready operand with stored tag 7 must ignore a tag-7 broadcast
        put(4'h6, 1, 4'h7, 32'hAAAA, 0, 4'h3, 0); step("R9");
        idle(); bc(4'h7, 32'hBBBB); step("R9");
        bc(4'h3, 32'h3333); step("R9");
        idle(); step("R9");
        step("R9");

        // R8/R10: fill all slots waiting on tags 8..15, refused allocs, drain
        for (int k = 0; k < N; k++) begin
            put(4'(k), 0, 4'(8 + k), 0, 1, 0, 32'(k)); step("R8");
        end
        put(4'hF, 1, 0, 32'hF00D, 1, 0, 32'hF00D); step("R8");
        step("R8");
        bc(4'hA, 32'hA0); step("R10");
        step("R10");
        step("R10");
        idle();
        for (int k = 0; k < N; k++) begin
            bc(4'(8 + k), 32'(k * 3)); step("R7");
        end
        idle(); step("R7"); step("R7"); step("R7");

        // Random mix
        for (int c = 0; c < 3000; c++) begin
            idle();
            if ($urandom % 2 == 0)
                put(4'($urandom), ($urandom % 2) == 0, 4'($urandom), $urandom,
                    ($urandom % 2) == 0, 4'($urandom), $urandom);
            if ($urandom % 2 == 0) bc(4'($urandom), $urandom);
            step("R6");
        end

        // Drain: broadcast every tag until the window empties
        for (int c = 0; c < 200 && !model_empty(); c++) begin
            idle(); bc(4'(c), 32'(c + 1000)); step("R7");
        end
        idle(); step("R7"); step("R7");
        chk(model_empty(), "R7", "window drained", 32'(!model_empty()), 0);
        chk(n_alloc == n_issue, "R7", "every accepted instruction issued",
            32'(n_issue), 32'(n_alloc));

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule